// File: doc/BRIEF.md
# Character LCD Start-Up and Message Sequencer

This block drives a two-line, sixteen-column character display over an 8-bit parallel write-only bus. It needs no processor. After reset it waits long enough for the display controller to power up. It then sends three set-up commands: two-line mode, display on with the cursor hidden, and entry mode with auto-increment. After that it shows a sequence of messages.

The first message greets the players. It stays on screen for a long hold. A second message then overwrites it with instructions. The sequencer then waits until the game reports a winner. At that point it writes a final message that names the winning player, and it stays idle for good.

Every transfer, whether command or character, follows the same fixed pattern: the bus is set up, the enable strobe is pulsed high for a set time, and then a fixed settling delay runs. The block never polls the display's busy flag. Each message is written as sixteen characters on line one, a cursor move to line two, sixteen characters on line two, and a return-home command.

Top module: `lcd_msg_seq`

## Requirements
- R1: While rstN is low, lcdEn, lcdRs and lcdData are all 0. After rstN rises, lcdEn stays low for at least PWRUP_CYC clock cycles before the first pulse. A reset at any point restarts the whole sequence.
- R2: lcdRw is 0 at all times.
- R3: The first three transfers are commands with lcdRs=0, in this order: 0x38 (8-bit bus, two lines), 0x0C (display on, cursor off, blink off), 0x06 (increment, no shift).
- R4: Each message is written as 34 transfers in this order: 16 characters with lcdRs=1, the command 0xC0 with lcdRs=0, 16 characters with lcdRs=1, and the command 0x02 with lcdRs=0.
- R5: The characters are ASCII and the messages come in this order:
  - Message 0: "Welcome to Pong!" and "First to 10 wins".
  - Message 1: "Get ready now..." and "Press serve key ".
  - Message 2: "Player 1 Wins!  " and "Game over. Reset".
- R6: Every enable pulse is high for exactly EN_CYC cycles. lcdData and lcdRs are set at least one cycle before the rising edge of lcdEn and hold steady until the cycle after its falling edge.
- R7: Between two pulses, lcdEn stays low for at least CMD_CYC cycles. After a 0x02 command it stays low for at least LONG_CYC cycles.
- R8: Between the 0x02 that ends message 0 and the first character of message 1, lcdEn stays low for at least LONG_CYC+HOLD_CYC cycles.
- R9: Message 2 starts only once message 1 has finished and winValid is high. While the block waits for winValid, lcdEn stays low.
- R10: In message 2, the character at column index 7 of line one is '1' when winPlayer=0 and '2' when winPlayer=1. winPlayer is sampled in the cycle in which winValid is accepted.
- R11: Once message 2 is complete, no further enable pulse appears until the next reset, whatever winValid and winPlayer do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| winValid | input | 1 | Level signal from the game: a player has reached ten goals |
| winPlayer | input | 1 | Winning player: 0 for player one, 1 for player two |
| lcdRs | output | 1 | Register select: 1 for character data, 0 for commands |
| lcdRw | output | 1 | Read/write select, held at 0 |
| lcdEn | output | 1 | Enable strobe |
| lcdData | output | 8 | Parallel data bus |

## Verification
The checker assumes the following about the inputs:
- rstN is the only input that can restart the timing.
- Every delay parameter is at least 1.
- CMD_CYC is no larger than PWRUP_CYC, so the minimum low-time rule also holds for the first pulse after reset.

The bench keeps to these assumptions. It uses small cycle counts with the same ordering: PWRUP_CYC ≥ LONG_CYC > CMD_CYC ≥ EN_CYC. It changes winValid and winPlayer only at falling clock edges, and it holds winValid as a level, as the game does once a score reaches ten. It covers two winner cases. In the first, winValid is raised well after message 1 has finished. In the second, winValid is held high from reset. The second run also takes a reset partway through message 0.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  localparam int LINE_LEN = 16;
  localparam int MSG_STEPS = 2 * LINE_LEN + 2;
  localparam int CFG_STEPS = 3;

  localparam logic [7:0] CMD_FUNC  = 8'h38;
  localparam logic [7:0] CMD_DISP  = 8'h0C;
  localparam logic [7:0] CMD_ENTRY = 8'h06;
  localparam logic [7:0] CMD_LINE2 = 8'hC0;
  localparam logic [7:0] CMD_HOME  = 8'h02;

  typedef enum logic [3:0] {
    ST_PWR, ST_NEXT, ST_SETUP, ST_EHI, ST_ELO, ST_WAIT, ST_HOLD, ST_WINW, ST_DONE
  } seqState_e;

  typedef enum logic [1:0] {
    DLY_EN, DLY_CMD, DLY_LONG, DLY_HOLD
  } dlySel_e;

  typedef struct packed {
    logic    present;
    logic    enSet;
    logic    enClr;
    logic    cntLoad;
    dlySel_e cntSel;
    logic    advance;
    logic    latchWin;
  } seqStrobe_t;

  function automatic logic [7:0] msgChar(input logic [1:0] msg, input logic line,
                                         input logic [3:0] col, input logic player);
    logic [127:0] txt;
    logic [7:0]   c;
    case ({msg, line})
      3'b000:  txt = "Welcome to Pong!";
      3'b001:  txt = "First to 10 wins";
      3'b010:  txt = "Get ready now...";
      3'b011:  txt = "Press serve key ";
      3'b100:  txt = "Player 1 Wins!  ";
      default: txt = "Game over. Reset";
    endcase
    c = txt[8*(15-int'(col)) +: 8];
    if (msg == 2'd2 && !line && col == 4'd7) c = player ? "2" : "1";
    return c;
  endfunction

endpackage

// File: rtl/lcd_seq_dpath.sv
module lcd_seq_dpath
  import lcd_seq_pkg::*;
#(
  parameter int PWRUP_CYC = 750000,
  parameter int CMD_CYC   = 2000,
  parameter int LONG_CYC  = 82000,
  parameter int HOLD_CYC  = 100000000,
  parameter int EN_CYC    = 23
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t stb,
  input  logic       winPlayer,
  output logic       cntDone,
  output logic       stepHome,
  output logic [1:0] msgIdx,
  output logic       lcdRs,
  output logic       lcdEn,
  output logic [7:0] lcdData
);

  localparam int MAX_A = (PWRUP_CYC > HOLD_CYC) ? PWRUP_CYC : HOLD_CYC;
  localparam int MAX_B = (LONG_CYC > CMD_CYC) ? LONG_CYC : CMD_CYC;
  localparam int MAX_C = (MAX_B > EN_CYC) ? MAX_B : EN_CYC;
  localparam int MAXC  = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int CW    = $clog2(MAXC + 1);
  localparam int PW    = $clog2(MSG_STEPS);

  logic [CW-1:0] cnt;
  logic [CW-1:0] loadVal;
  logic          inCfg;
  logic [1:0]    cfgIdx;
  logic [PW-1:0] posIdx;
  logic          winReg;
  logic          enReg;
  logic          rsReg;
  logic [7:0]    dataReg;
  logic          stepRs;
  logic [7:0]    stepData;

  // Delay counter: a load of N-1 gives N cycles in the waiting state
  always_comb begin
    case (stb.cntSel)
      DLY_EN:   loadVal = CW'(EN_CYC - 1);
      DLY_CMD:  loadVal = CW'(CMD_CYC - 1);
      DLY_LONG: loadVal = CW'(LONG_CYC - 1);
      default:  loadVal = CW'(HOLD_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= CW'(PWRUP_CYC - 1);
    else if (stb.cntLoad) cnt <= loadVal;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign cntDone = (cnt == '0);

  // Step position: configuration commands, then message/position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCfg  <= 1'b1;
      cfgIdx <= '0;
      posIdx <= '0;
      msgIdx <= '0;
    end else if (stb.advance) begin
      if (inCfg) begin
        if (cfgIdx == 2'(CFG_STEPS - 1)) begin
          inCfg  <= 1'b0;
          cfgIdx <= '0;
        end else begin
          cfgIdx <= cfgIdx + 1'b1;
        end
      end else if (posIdx == PW'(MSG_STEPS - 1)) begin
        posIdx <= '0;
        msgIdx <= msgIdx + 1'b1;
      end else begin
        posIdx <= posIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) winReg <= 1'b0;
    else if (stb.latchWin) winReg <= winPlayer;
  end

  assign stepHome = !inCfg && (posIdx == PW'(MSG_STEPS - 1));

  // Byte and register select for the current step
  always_comb begin
    stepRs   = 1'b0;
    stepData = CMD_HOME;
    if (inCfg) begin
      case (cfgIdx)
        2'd0:    stepData = CMD_FUNC;
        2'd1:    stepData = CMD_DISP;
        default: stepData = CMD_ENTRY;
      endcase
    end else if (posIdx < PW'(LINE_LEN)) begin
      stepRs   = 1'b1;
      stepData = msgChar(msgIdx, 1'b0, posIdx[3:0], winReg);
    end else if (posIdx == PW'(LINE_LEN)) begin
      stepData = CMD_LINE2;
    end else if (posIdx < PW'(MSG_STEPS - 1)) begin
      stepRs   = 1'b1;
      stepData = msgChar(msgIdx, 1'b1, 4'(posIdx - PW'(LINE_LEN + 1)), winReg);
    end
  end

  // Registered pin drivers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsReg   <= 1'b0;
      dataReg <= '0;
    end else if (stb.present) begin
      rsReg   <= stepRs;
      dataReg <= stepData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enReg <= 1'b0;
    else if (stb.enSet) enReg <= 1'b1;
    else if (stb.enClr) enReg <= 1'b0;
  end

  assign lcdRs   = rsReg;
  assign lcdEn   = enReg;
  assign lcdData = dataReg;

endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cntDone,
  input  logic       stepHome,
  input  logic [1:0] msgIdx,
  input  logic       winValid,
  output seqStrobe_t stb
);

  seqState_e st;
  seqState_e nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_PWR;
    else st <= nxt;
  end

  always_comb begin
    stb = '0;
    nxt = st;
    case (st)
      ST_PWR: if (cntDone) nxt = ST_NEXT;
      ST_NEXT: begin
        stb.present = 1'b1;
        nxt = ST_SETUP;
      end
      ST_SETUP: begin
        stb.enSet   = 1'b1;
        stb.cntLoad = 1'b1;
        stb.cntSel  = DLY_EN;
        nxt = ST_EHI;
      end
      ST_EHI: if (cntDone) begin
        stb.enClr = 1'b1;
        nxt = ST_ELO;
      end
      ST_ELO: begin
        stb.cntLoad = 1'b1;
        stb.cntSel  = stepHome ? DLY_LONG : DLY_CMD;
        nxt = ST_WAIT;
      end
      ST_WAIT: if (cntDone) begin
        if (!stepHome) begin
          stb.advance = 1'b1;
          nxt = ST_NEXT;
        end else begin
          case (msgIdx)
            2'd0: begin
              stb.advance = 1'b1;
              stb.cntLoad = 1'b1;
              stb.cntSel  = DLY_HOLD;
              nxt = ST_HOLD;
            end
            2'd1: begin
              stb.advance = 1'b1;
              nxt = ST_WINW;
            end
            default: nxt = ST_DONE;
          endcase
        end
      end
      ST_HOLD: if (cntDone) nxt = ST_NEXT;
      ST_WINW: if (winValid) begin
        stb.latchWin = 1'b1;
        nxt = ST_NEXT;
      end
      default: nxt = ST_DONE;
    endcase
  end

endmodule

// File: rtl/lcd_msg_seq.sv
module lcd_msg_seq
  import lcd_seq_pkg::*;
#(
  parameter int PWRUP_CYC = 750000,
  parameter int CMD_CYC   = 2000,
  parameter int LONG_CYC  = 82000,
  parameter int HOLD_CYC  = 100000000,
  parameter int EN_CYC    = 23
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       winValid,
  input  logic       winPlayer,
  output logic       lcdRs,
  output logic       lcdRw,
  output logic       lcdEn,
  output logic [7:0] lcdData
);

  seqStrobe_t stb;
  logic       cntDone;
  logic       stepHome;
  logic [1:0] msgIdx;

  lcd_seq_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cntDone  (cntDone),
    .stepHome (stepHome),
    .msgIdx   (msgIdx),
    .winValid (winValid),
    .stb      (stb)
  );

  lcd_seq_dpath #(
    .PWRUP_CYC (PWRUP_CYC),
    .CMD_CYC   (CMD_CYC),
    .LONG_CYC  (LONG_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .EN_CYC    (EN_CYC)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .winPlayer (winPlayer),
    .cntDone   (cntDone),
    .stepHome  (stepHome),
    .msgIdx    (msgIdx),
    .lcdRs     (lcdRs),
    .lcdEn     (lcdEn),
    .lcdData   (lcdData)
  );

  assign lcdRw = 1'b0;

endmodule

// File: rtl/lcd_msg_seq_chk.sv
module lcd_msg_seq_chk #(
  parameter int EN_CYC  = 23,
  parameter int CMD_CYC = 2000
) (
  input logic       clk,
  input logic       rstN,
  input logic       lcdEn,
  input logic       lcdRs,
  input logic       lcdRw,
  input logic [7:0] lcdData
);

  int unsigned hiCnt;
  int unsigned loCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt <= 0;
      loCnt <= 0;
    end else begin
      hiCnt <= lcdEn ? hiCnt + 1 : 0;
      loCnt <= lcdEn ? 0 : loCnt + 1;
    end
  end

  // R2
  rw_low_chk: assert property (@(posedge clk) disable iff (!rstN) lcdRw == 1'b0);

  // R6
  en_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lcdEn) |-> hiCnt == EN_CYC);

  // R6
  en_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    lcdEn |-> hiCnt < EN_CYC);

  // R6
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lcdEn || $fell(lcdEn)) |-> ($stable(lcdData) && $stable(lcdRs)));

  // R7
  low_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lcdEn) |-> loCnt >= CMD_CYC);

endmodule

bind lcd_msg_seq lcd_msg_seq_chk #(.EN_CYC(EN_CYC), .CMD_CYC(CMD_CYC)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .lcdEn   (lcdEn),
  .lcdRs   (lcdRs),
  .lcdRw   (lcdRw),
  .lcdData (lcdData)
);

// File: tb/lcd_msg_seq_tb_top.sv
module lcd_msg_seq_tb_top;

  localparam int P = 20;
  localparam int C = 5;
  localparam int L = 12;
  localparam int H = 30;
  localparam int E = 3;

  logic       clk = 1'b0;
  logic       rstN;
  logic       winValid;
  logic       winPlayer;
  logic       lcdRs;
  logic       lcdRw;
  logic       lcdEn;
  logic [7:0] lcdData;

  int nChk = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  lcd_msg_seq #(
    .PWRUP_CYC (P), .CMD_CYC (C), .LONG_CYC (L), .HOLD_CYC (H), .EN_CYC (E)
  ) dut_i (
    .clk (clk), .rstN (rstN), .winValid (winValid), .winPlayer (winPlayer),
    .lcdRs (lcdRs), .lcdRw (lcdRw), .lcdEn (lcdEn), .lcdData (lcdData)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] txtOf(input int msg, input int line);
    case (msg * 2 + line)
      0: return "Welcome to Pong!";
      1: return "First to 10 wins";
      2: return "Get ready now...";
      3: return "Press serve key ";
      4: return "Player 1 Wins!  ";
      default: return "Game over. Reset";
    endcase
  endfunction

  function automatic logic [8:0] expStep(input int msg, input int pos, input bit player);
    logic [127:0] t;
    logic [7:0]   ch;
    if (pos == 16) return {1'b0, 8'hC0};
    if (pos == 33) return {1'b0, 8'h02};
    t  = txtOf(msg, pos < 16 ? 0 : 1);
    ch = t[8*(15 - (pos < 16 ? pos : pos - 17)) +: 8];
    if (msg == 2 && pos == 7) ch = player ? 8'h32 : 8'h31;
    return {1'b1, ch};
  endfunction

  task automatic capture(output bit rs, output logic [7:0] d, output int lo, output int hi);
    lo = 0;
    while (!lcdEn) begin
      lo++;
      @(negedge clk);
    end
    rs = lcdRs;
    d  = lcdData;
    chk(lcdRw == 1'b0, "R2 rw", int'(lcdRw), 0);
    hi = 0;
    while (lcdEn) begin
      hi++;
      @(negedge clk);
    end
  endtask

  task automatic runCfg();
    bit         rs;
    logic [7:0] d;
    int         lo;
    int         hi;
    logic [7:0] exp3 [3];
    exp3[0] = 8'h38; exp3[1] = 8'h0C; exp3[2] = 8'h06;
    for (int k = 0; k < 3; k++) begin
      capture(rs, d, lo, hi);
      chk(rs == 1'b0 && d == exp3[k], "R3 config command", int'({rs, d}), int'({1'b0, exp3[k]}));
      chk(hi == E, "R6 enable width", hi, E);
      if (k == 0) chk(lo >= P && lo <= P + 4, "R1 power-up wait", lo, P);
      else        chk(lo >= C && lo <= C + 3, "R7 command gap", lo, C);
    end
  endtask

  task automatic runMsg(input int msg, input bit player, input int loMin, input int loMax,
                        input string firstReq);
    bit         rs;
    logic [7:0] d;
    int         lo;
    int         hi;
    logic [8:0] ex;
    for (int pos = 0; pos < 34; pos++) begin
      capture(rs, d, lo, hi);
      ex = expStep(msg, pos, player);
      if (msg == 2 && pos == 7)
        chk({rs, d} == ex, "R10 winner digit", int'({rs, d}), int'(ex));
      else if (pos == 16 || pos == 33)
        chk({rs, d} == ex, "R4 message command", int'({rs, d}), int'(ex));
      else
        chk({rs, d} == ex, "R5 message character", int'({rs, d}), int'(ex));
      chk(hi == E, "R6 enable width", hi, E);
      if (pos == 0) chk(lo >= loMin && lo <= loMax, firstReq, lo, loMin);
      else          chk(lo >= C && lo <= C + 3, "R7 character gap", lo, C);
    end
  endtask

  task automatic checkReset();
    chk(lcdEn == 1'b0 && lcdRs == 1'b0 && lcdData == 8'h00 && lcdRw == 1'b0,
        "R1 reset outputs", int'({lcdEn, lcdRs, lcdRw, lcdData}), 0);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    bit         rs;
    logic [7:0] d;
    int         lo;
    int         hi;
    int         pulses;

    // Run A: winner raised late, player one
    rstN = 1'b0; winValid = 1'b0; winPlayer = 1'b0;
    repeat (3) @(negedge clk);
    checkReset();
    rstN = 1'b1;
    runCfg();
    runMsg(0, 1'b0, C, C + 3, "R7 gap after entry mode");
    runMsg(1, 1'b0, L + H, L + H + 3, "R8 hold after first message");
    pulses = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (lcdEn) pulses++;
    end
    chk(pulses == 0, "R9 idle while waiting for winner", pulses, 0);
    winPlayer = 1'b0;
    winValid  = 1'b1;
    runMsg(2, 1'b0, 1, 6, "R9 start after winner");
    pulses = 0;
    for (int i = 0; i < 300; i++) begin
      if (i == 50) winValid = 1'b0;
      if (i == 100) winPlayer = 1'b1;
      if (i == 150) winValid = 1'b1;
      @(negedge clk);
      if (lcdEn) pulses++;
    end
    chk(pulses == 0, "R11 no pulse after final message", pulses, 0);

    // Run B: winner held from reset, player two, reset inside message 0
    rstN = 1'b0; winValid = 1'b1; winPlayer = 1'b1;
    repeat (2) @(negedge clk);
    checkReset();
    rstN = 1'b1;
    runCfg();
    for (int k = 0; k < 5; k++) capture(rs, d, lo, hi);
    rstN = 1'b0;
    @(negedge clk);
    checkReset();
    @(negedge clk);
    rstN = 1'b1;
    runCfg();
    runMsg(0, 1'b1, C, C + 3, "R7 gap after entry mode");
    runMsg(1, 1'b1, L + H, L + H + 3, "R8 hold after first message");
    runMsg(2, 1'b1, L, L + 5, "R7 long gap after return home");
    pulses = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (lcdEn) pulses++;
    end
    chk(pulses == 0, "R11 no pulse after final message", pulses, 0);

    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule